// File: doc/BRIEF.md
# Speculative Thread Dispatch Sequencer

This controller hands program threads to a small array of CPUs and retires them strictly in program order. Every thread is described by an entry in a backing descriptor table. An entry holds the thread's first instruction address, two candidate successor thread identifiers, a register dependency mask and a mode bit that marks the thread as explicit (0) or implicit/speculative (1). A small direct-mapped descriptor cache sits in front of the table. On a miss, dispatch waits a fixed number of cycles while the entry is fetched.

The block always holds a "next thread" identifier. When that thread's descriptor is cached and a CPU is free, the block drives the start PC, a per-CPU private stack pointer, the dependency mask and the mode to the lowest-numbered free CPU. It then predicts the following thread with a 2-bit saturating counter kept for each descriptor. In-flight threads sit in a circular order window. Only the oldest thread may retire, and only after its CPU has reported completion together with the thread's actual successor.

A wrong successor at retirement discards all younger threads and redirects dispatch. A squash reported by a CPU discards that thread and every younger one, and dispatch restarts from the squashed thread. When the next thread's mode differs from the mode of the threads in flight, dispatch waits until the window is empty.

Top module: `spec_thread_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, disp_valid, commit_valid and kill_mask are all zero, desc_rd_idx is 0 and every CPU is free.
- R2: A dispatch drives disp_pc from descriptor bits [AW-1:0], disp_deps from bits [AW+2*IW+REGW-1:AW+2*IW] and disp_mode from the top bit. It drives disp_sp = SP_TOP - cpu*SP_STRIDE and selects the lowest-numbered free CPU. The successor fields are succ0 at [AW+IW-1:AW] and succ1 at [AW+2*IW-1:AW+IW].
- R3: The descriptor cache is direct mapped and indexed by the low bits of the thread id. On a miss, desc_rd_idx shows the id and the line fills after MISS_LAT cycles, so the first dispatch after reset appears MISS_LAT cycles after reset release. A hit dispatches in the same cycle.
- R4: The next thread is succ1 when the current descriptor's counter is 2 or 3, and succ0 otherwise. Counters reset to 1.
- R5: At retirement the retiring thread's counter increments (saturating at 3) if the actual successor equals succ1. Otherwise it decrements (saturating at 0) if the actual successor equals succ0.
- R6: Threads retire in dispatch order. Only the oldest in-flight thread retires, and only once its CPU has reported completion. A completed younger thread waits.
- R7: At most NCPU threads are in flight. Dispatch stops while every CPU is busy.
- R8: A squash from a busy CPU sets kill_mask to the CPUs of that thread and all younger threads in the same cycle. Dispatch then restarts from the squashed thread, and older threads still retire. A squash from an idle CPU has no effect.
- R9: When the retiring thread's actual successor differs from its prediction, kill_mask marks the CPUs of all younger threads in the retiring cycle, and the next dispatch is the actual successor.
- R10: A thread whose mode bit differs from the current mode is not dispatched while any thread is in flight. It is dispatched once the window empties.
- R11: A completion report from a CPU that holds no thread is ignored, and a thread later placed on that CPU still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_rd_idx | output | IW | Thread id whose descriptor is being looked up |
| desc_rd_data | input | DW | Backing table entry for desc_rd_idx |
| disp_valid | output | 1 | A thread is dispatched this cycle |
| disp_cpu | output | CW | Target CPU |
| disp_id | output | IW | Dispatched thread id |
| disp_pc | output | AW | First instruction address |
| disp_sp | output | AW | Private stack pointer for the target CPU |
| disp_deps | output | REGW | Register dependency mask |
| disp_mode | output | 1 | 1 = implicit, 0 = explicit |
| cpl_valid | input | 1 | A CPU reports completion |
| cpl_cpu | input | CW | Reporting CPU |
| cpl_next | input | IW | Actual successor of the completed thread |
| sq_valid | input | 1 | A CPU reports a squash |
| sq_cpu | input | CW | Squashed CPU |
| commit_valid | output | 1 | The oldest thread retires this cycle |
| commit_id | output | IW | Retiring thread id |
| kill_mask | output | NCPU | CPUs whose threads are discarded this cycle |

## Verification
The sequencer is driven with a straight chain of threads that all follow their succ0 prediction. This shows cache-miss timing, field routing and the window limit without any redirects. Completions are sent out of order to separate in-order retirement from simple completion forwarding. A squash in the middle of the window and a wrong successor at retirement are then used to tell a squash restart (which re-dispatches the squashed thread from the cache) from a misprediction redirect (which fetches the actual successor and retrains the counter, so the same thread is later predicted differently). A mode change, combined with stray squash and completion reports from idle CPUs, shows that the barrier holds and that stale reports leave no trace.

// File: rtl/spec_thread_seq.sv
module spec_thread_seq #(
  parameter int NCPU     = 4,
  parameter int NDESC    = 8,
  parameter int AW       = 16,
  parameter int REGW     = 8,
  parameter int CLINES   = 4,
  parameter int MISS_LAT = 4,
  parameter logic [AW-1:0] SP_TOP    = 16'hF000,
  parameter logic [AW-1:0] SP_STRIDE = 16'h0400,
  localparam int CW = $clog2(NCPU),
  localparam int IW = $clog2(NDESC),
  localparam int DW = 1 + REGW + 2*IW + AW
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [IW-1:0]   desc_rd_idx,
  input  logic [DW-1:0]   desc_rd_data,
  output logic            disp_valid,
  output logic [CW-1:0]   disp_cpu,
  output logic [IW-1:0]   disp_id,
  output logic [AW-1:0]   disp_pc,
  output logic [AW-1:0]   disp_sp,
  output logic [REGW-1:0] disp_deps,
  output logic            disp_mode,
  input  logic            cpl_valid,
  input  logic [CW-1:0]   cpl_cpu,
  input  logic [IW-1:0]   cpl_next,
  input  logic            sq_valid,
  input  logic [CW-1:0]   sq_cpu,
  output logic            commit_valid,
  output logic [IW-1:0]   commit_id,
  output logic [NCPU-1:0] kill_mask
);
  localparam int LW = $clog2(CLINES);
  localparam int MW = $clog2(MISS_LAT + 1);

  logic [DW-1:0]   c_data [CLINES];
  logic [IW-1:0]   c_tag  [CLINES];
  logic [CLINES-1:0] c_vld;
  logic [1:0]      ctr [NDESC];
  logic [IW-1:0]   e_id [NCPU], e_pred [NCPU], e_s0 [NCPU], e_s1 [NCPU];
  logic [CW-1:0]   e_cpu [NCPU];
  logic [IW-1:0]   cnext [NCPU];
  logic [CW-1:0]   head;
  logic [CW:0]     cnt;
  logic [NCPU-1:0] busy, cdone;
  logic [IW-1:0]   next_id;
  logic            mode_cur;
  logic [MW-1:0]   mcnt;

  wire [LW-1:0]   lidx   = next_id[LW-1:0];
  wire            hit    = c_vld[lidx] && (c_tag[lidx] == next_id);
  wire [DW-1:0]   d      = c_data[lidx];
  wire [IW-1:0]   d_s0   = d[AW +: IW];
  wire [IW-1:0]   d_s1   = d[AW+IW +: IW];
  wire            d_mode = d[DW-1];
  wire [IW-1:0]   pred   = ctr[next_id][1] ? d_s1 : d_s0;
  wire [CW-1:0]   hcpu   = e_cpu[head];
  wire [IW-1:0]   actual = cnext[hcpu];

  logic          free_ok, sq_hit;
  logic [CW-1:0] free_cpu, sq_pos;

  always_comb begin
    free_ok  = 1'b0;
    free_cpu = '0;
    for (int i = NCPU-1; i >= 0; i--)
      if (!busy[i]) begin
        free_ok  = 1'b1;
        free_cpu = CW'(i);
      end
    sq_hit = 1'b0;
    sq_pos = '0;
    for (int i = 0; i < NCPU; i++)
      if (sq_valid && ((CW+1)'(i) < cnt) && (e_cpu[CW'(head + CW'(i))] == sq_cpu)) begin
        sq_hit = 1'b1;
        sq_pos = CW'(i);
      end
  end

  wire do_commit = (cnt != '0) && cdone[hcpu] && !sq_hit;
  wire mispred   = do_commit && (actual != e_pred[head]);
  wire redirect  = sq_hit || mispred;
  wire mode_blk  = (d_mode != mode_cur) && (cnt != '0);
  wire do_disp   = hit && !mode_blk && (cnt < (CW+1)'(NCPU)) && free_ok && !redirect;

  always_comb begin
    kill_mask = '0;
    for (int i = 0; i < NCPU; i++)
      if (((CW+1)'(i) < cnt) &&
          ((sq_hit && (CW'(i) >= sq_pos)) || (mispred && i >= 1)))
        kill_mask[e_cpu[CW'(head + CW'(i))]] = 1'b1;
  end

  assign desc_rd_idx  = next_id;
  assign disp_valid   = do_disp;
  assign disp_cpu     = free_cpu;
  assign disp_id      = next_id;
  assign disp_pc      = d[AW-1:0];
  assign disp_sp      = SP_TOP - AW'(free_cpu) * SP_STRIDE;
  assign disp_deps    = d[AW+2*IW +: REGW];
  assign disp_mode    = d_mode;
  assign commit_valid = do_commit;
  assign commit_id    = e_id[head];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_vld    <= '0;
      busy     <= '0;
      cdone    <= '0;
      head     <= '0;
      cnt      <= '0;
      next_id  <= '0;
      mode_cur <= 1'b0;
      mcnt     <= '0;
      for (int i = 0; i < CLINES; i++) begin
        c_data[i] <= '0;
        c_tag[i]  <= '0;
      end
      for (int i = 0; i < NDESC; i++) ctr[i] <= 2'd1;
      for (int i = 0; i < NCPU; i++) begin
        e_id[i] <= '0; e_pred[i] <= '0; e_s0[i] <= '0; e_s1[i] <= '0;
        e_cpu[i] <= '0; cnext[i] <= '0;
      end
    end else begin
      if (!hit && !redirect) begin
        if (mcnt == MW'(MISS_LAT - 1)) begin
          mcnt         <= '0;
          c_vld[lidx]  <= 1'b1;
          c_tag[lidx]  <= next_id;
          c_data[lidx] <= desc_rd_data;
        end else
          mcnt <= mcnt + MW'(1);
      end else
        mcnt <= '0;

      if (cpl_valid && busy[cpl_cpu]) begin
        cdone[cpl_cpu] <= 1'b1;
        cnext[cpl_cpu] <= cpl_next;
      end

      if (do_commit) begin
        head        <= head + CW'(1);
        busy[hcpu]  <= 1'b0;
        cdone[hcpu] <= 1'b0;
        if (actual == e_s1[head]) begin
          if (ctr[e_id[head]] != 2'd3) ctr[e_id[head]] <= ctr[e_id[head]] + 2'd1;
        end else if (actual == e_s0[head]) begin
          if (ctr[e_id[head]] != 2'd0) ctr[e_id[head]] <= ctr[e_id[head]] - 2'd1;
        end
      end

      for (int i = 0; i < NCPU; i++)
        if (kill_mask[i]) begin
          busy[i]  <= 1'b0;
          cdone[i] <= 1'b0;
        end

      if (sq_hit) begin
        cnt     <= {1'b0, sq_pos};
        next_id <= e_id[CW'(head + sq_pos)];
      end else if (mispred) begin
        cnt     <= '0;
        next_id <= actual;
      end else begin
        cnt <= cnt + (CW+1)'(do_disp) - (CW+1)'(do_commit);
        if (do_disp) begin
          next_id  <= pred;
          mode_cur <= d_mode;
          busy[free_cpu] <= 1'b1;
          e_id  [CW'(head + cnt[CW-1:0])] <= next_id;
          e_pred[CW'(head + cnt[CW-1:0])] <= pred;
          e_s0  [CW'(head + cnt[CW-1:0])] <= d_s0;
          e_s1  [CW'(head + cnt[CW-1:0])] <= d_s1;
          e_cpu [CW'(head + cnt[CW-1:0])] <= free_cpu;
        end
      end
    end
  end
endmodule

// File: rtl/spec_thread_seq_chk.sv
module spec_thread_seq_chk #(
  parameter int NCPU = 4,
  localparam int CW = $clog2(NCPU)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_valid,
  input logic [CW-1:0]   disp_cpu,
  input logic            disp_mode,
  input logic            commit_valid,
  input logic [NCPU-1:0] kill_mask,
  input logic            sq_valid,
  input logic [CW-1:0]   sq_cpu,
  input logic [NCPU-1:0] busy,
  input logic [NCPU-1:0] cdone,
  input logic [CW:0]     cnt,
  input logic [CW-1:0]   head,
  input logic            mode_cur
);
  a_r2_disp_to_free: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !busy[disp_cpu]);
  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (CW+1)'(NCPU));
  a_r8_kill_busy_only: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_mask & ~busy) == '0);
  a_r8_squash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && busy[sq_cpu]) |-> (!disp_valid && !commit_valid));
  a_r6_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head == CW'($past(head) + CW'(1)));
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && cnt != '0) |-> disp_mode == mode_cur);
  a_r11_done_busy_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cdone & ~busy) == '0);
endmodule

bind spec_thread_seq spec_thread_seq_chk #(.NCPU(NCPU)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_cpu(disp_cpu),
  .disp_mode(disp_mode), .commit_valid(commit_valid), .kill_mask(kill_mask),
  .sq_valid(sq_valid), .sq_cpu(sq_cpu), .busy(busy), .cdone(cdone),
  .cnt(cnt), .head(head), .mode_cur(mode_cur)
);

// File: tb/spec_thread_seq_tb_top.sv
`timescale 1ns/100ps
module spec_thread_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  desc_rd_idx;
  logic [30:0] desc_rd_data;
  logic        disp_valid, disp_mode, commit_valid;
  logic [1:0]  disp_cpu;
  logic [2:0]  disp_id, commit_id;
  logic [15:0] disp_pc, disp_sp;
  logic [7:0]  disp_deps;
  logic        cpl_valid = 0, sq_valid = 0;
  logic [1:0]  cpl_cpu = 0, sq_cpu = 0;
  logic [2:0]  cpl_next = 0;
  logic [3:0]  kill_mask;
  logic [30:0] tbl [8];

  int nvec = 0, nfail = 0, nd = 0, nc = 0;
  int ld_id [64], ld_cpu [64], ld_pc [64], ld_sp [64], ld_deps [64], ld_mode [64];
  int lc_id [64];

  always #2.5 clk = ~clk;
  assign desc_rd_data = tbl[desc_rd_idx];

  spec_thread_seq dut_i (
    .clk(clk), .rst_n(rst_n), .desc_rd_idx(desc_rd_idx), .desc_rd_data(desc_rd_data),
    .disp_valid(disp_valid), .disp_cpu(disp_cpu), .disp_id(disp_id), .disp_pc(disp_pc),
    .disp_sp(disp_sp), .disp_deps(disp_deps), .disp_mode(disp_mode),
    .cpl_valid(cpl_valid), .cpl_cpu(cpl_cpu), .cpl_next(cpl_next),
    .sq_valid(sq_valid), .sq_cpu(sq_cpu), .commit_valid(commit_valid),
    .commit_id(commit_id), .kill_mask(kill_mask));

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (disp_valid && nd < 64) begin
        ld_id[nd] = disp_id; ld_cpu[nd] = disp_cpu; ld_pc[nd] = disp_pc;
        ld_sp[nd] = disp_sp; ld_deps[nd] = disp_deps; ld_mode[nd] = disp_mode;
        nd++;
      end
      if (commit_valid && nc < 64) begin
        lc_id[nc] = commit_id;
        nc++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  function automatic logic [30:0] mk(input int pc, input int s0, input int s1,
                                     input int deps, input bit mode);
    return {mode, 8'(deps), 3'(s1), 3'(s0), 16'(pc)};
  endfunction

  task automatic set_chain();
    for (int i = 0; i < 8; i++)
      tbl[i] = mk(16'h1000 + i * 256, (i + 1) % 8, (i + 5) % 8, 8'h10 + i, 1'b0);
  endtask

  task automatic do_reset(input bit check_idle);
    rst_n = 0; cpl_valid = 0; sq_valid = 0;
    step(2);
    if (check_idle) begin
      chk(!disp_valid && !commit_valid && kill_mask == 0, "R1 in reset",
          {disp_valid, commit_valid, kill_mask}, 0);
    end
    nd = 0; nc = 0;
    rst_n = 1;
  endtask

  task automatic wait_disp(input int n);
    for (int k = 0; k < 200 && nd < n; k++) step();
  endtask

  task automatic cpl(input int c, input int nxt);
    cpl_valid = 1; cpl_cpu = 2'(c); cpl_next = 3'(nxt);
    step();
    cpl_valid = 0;
  endtask

  task automatic t_fill();
    set_chain();
    do_reset(1);
    #0.5;
    chk(!disp_valid && !commit_valid && kill_mask == 0 && desc_rd_idx == 0,
        "R1 after release", {disp_valid, commit_valid, kill_mask, desc_rd_idx}, 0);
    step(3);
    chk(!disp_valid, "R3 miss latency early", disp_valid, 0);
    step();
    chk(disp_valid && disp_id == 0, "R3 miss latency", {disp_valid, disp_id}, 4'b1000);
    wait_disp(4);
    for (int k = 0; k < 4; k++) begin
      chk(ld_id[k] == k && ld_cpu[k] == k, "R2 id/cpu", ld_id[k] * 16 + ld_cpu[k], k * 17);
      chk(ld_pc[k] == 16'h1000 + k * 256, "R2 pc", ld_pc[k], 16'h1000 + k * 256);
      chk(ld_sp[k] == 16'hF000 - k * 16'h0400, "R2 sp", ld_sp[k], 16'hF000 - k * 16'h0400);
      chk(ld_deps[k] == 8'h10 + k && ld_mode[k] == 0, "R2 deps/mode", ld_deps[k], 8'h10 + k);
    end
    step(20);
    chk(nd == 4, "R7 window full", nd, 4);
  endtask

  task automatic t_inorder();
    set_chain();
    do_reset(0);
    wait_disp(4);
    cpl(2, 3);
    step(4);
    chk(nc == 0, "R6 younger waits", nc, 0);
    cpl(0, 1);
    step();
    chk(nc == 1 && lc_id[0] == 0, "R6 head retires", nc * 16 + lc_id[0], 16);
    cpl(1, 2);
    step(2);
    chk(nc == 3 && lc_id[1] == 1 && lc_id[2] == 2, "R6 order",
        nc * 256 + lc_id[1] * 16 + lc_id[2], 3 * 256 + 16 + 2);
    wait_disp(5);
    chk(ld_id[4] == 4 && ld_cpu[4] == 0, "R2 lowest free cpu", ld_id[4] * 16 + ld_cpu[4], 64);
  endtask

  task automatic t_squash();
    set_chain();
    do_reset(0);
    wait_disp(4);
    sq_valid = 1; sq_cpu = 2'd1;
    #0.5;
    chk(kill_mask == 4'b1110, "R8 kill younger", kill_mask, 4'b1110);
    step();
    sq_valid = 0;
    #0.5;
    chk(disp_valid && disp_id == 1 && disp_cpu == 1, "R3 hit no stall / R8 restart",
        {disp_valid, disp_id, disp_cpu}, 6'b100101);
    wait_disp(7);
    for (int k = 4; k < 7; k++)
      chk(ld_id[k] == k - 3 && ld_cpu[k] == k - 3, "R8 redispatch", ld_id[k], k - 3);
    cpl(0, 1);
    step();
    chk(nc == 1 && lc_id[0] == 0, "R8 older survives", nc * 16 + lc_id[0], 16);
  endtask

  task automatic t_mispred();
    set_chain();
    tbl[5] = mk(16'h1500, 0, 2, 8'h15, 1'b0);
    do_reset(0);
    wait_disp(4);
    cpl(0, 5);
    chk(commit_valid && kill_mask == 4'b1110, "R9 kill on mispredict",
        {commit_valid, kill_mask}, 5'b11110);
    wait_disp(7);
    chk(ld_id[4] == 5 && ld_cpu[4] == 0, "R9 redirect", ld_id[4] * 16 + ld_cpu[4], 16'h50);
    chk(ld_id[5] == 0, "R4 weak counter picks succ0", ld_id[5], 0);
    chk(ld_id[6] == 5, "R5 trained counter picks succ1", ld_id[6], 5);
  endtask

  task automatic t_mode();
    set_chain();
    for (int i = 1; i < 4; i++) tbl[i][30] = 1'b1;
    do_reset(0);
    wait_disp(1);
    step(15);
    chk(nd == 1, "R10 mode barrier", nd, 1);
    sq_valid = 1; sq_cpu = 2'd2;
    #0.5;
    chk(kill_mask == 0, "R8 idle squash", kill_mask, 0);
    step();
    sq_valid = 0;
    cpl(1, 0);
    cpl(0, 1);
    step();
    chk(nc == 1 && lc_id[0] == 0, "R8 idle squash harmless", nc * 16 + lc_id[0], 16);
    wait_disp(3);
    chk(ld_id[1] == 1 && ld_mode[1] == 1 && ld_cpu[1] == 0, "R10 after drain",
        ld_id[1] * 256 + ld_mode[1] * 16 + ld_cpu[1], 16'h110);
    chk(ld_id[2] == 2 && ld_cpu[2] == 1, "R10 same mode follows", ld_id[2] * 16 + ld_cpu[2], 16'h21);
    cpl(0, 2);
    step(10);
    chk(nc == 2, "R11 stale completion ignored", nc, 2);
  endtask

  initial begin
    t_fill();
    t_inorder();
    t_squash();
    t_mispred();
    t_mode();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #200000;
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule